// File: doc/BRIEF.md
# Video Text Overlay Generator

This block puts one short line of text on top of a video picture. It watches separated horizontal and vertical sync and counts scan lines within each frame. Once the count reaches a programmable first line, it sends the font dots of a row of characters, one bit per pixel-clock slot, onto a single overlay output. An external mixer keys that output into the analog picture.

Every drawn line starts a fixed, programmable number of clocks after the sync edge. No software latency sits in the path, so the text lands at the same horizontal position on every line and shows no jitter. Text is held as font bytes that the host has already looked up from character codes. A character-row-major buffer holds one byte per character per font row. Each font row is repeated on two scan lines to give a more even aspect ratio.

Top module: `osd_overlay_gen`

## Requirements
- R1: After reset the overlay output is low and the scan line count is zero, so the first horizontal sync rising edge starts line 1.
- R2: A rising edge on vertical sync clears the line count, so the next horizontal sync rising edge starts line 1 again.
- R3: Line k is in the drawing band only when start_line <= k < start_line + 16. On any other line the output stays low for the whole line.
- R4: Within the band, relative line j = k - start_line shows font row j/2 (integer division). The two lines with j = 14 and 15 are blank.
- R5: Character c (0 to 8) of font row r comes from the buffer byte at address r*9 + c. Its 8 dots are sent MSB first, each for 2 clocks, with a 1 meaning the output is high.
- R6: Let clock 0 be the first rising clock edge at which horizontal sync is sampled high, and D the delay setting. Dot 0 of character 0 shows after edge D+2, and the output is low before that and after the ninth character.
- R7: Each character period is 22 clocks: 16 dot clocks and then 6 clocks with the output low.
- R8: A buffer write of a byte at an address below 63 takes effect on later lines. A write to address 63 changes nothing on screen.
- R9: A horizontal sync pulse held high for several clocks advances the line count once only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Separated horizontal sync, active high, synchronous to clk |
| vsync_i | input | 1 | Separated vertical sync, active high, synchronous to clk |
| start_line_i | input | 10 | First scan line of the drawing band |
| h_delay_i | input | 8 | Clocks from the sync edge to the first dot, less two |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_addr_i | input | 6 | Buffer address, row*9 + character |
| wr_data_i | input | 8 | Font byte, MSB is the leftmost dot |
| ovl_o | output | 1 | Overlay dot output |

## Verification
A wrong line count shows up as the whole text band moved up or down by whole scan lines. A font row can also appear on one line of a pair only, and this can be seen on the first line of the band after a vertical sync. A phase or character counter that is off shows within one 22-clock character period: dots land one slot early or late, a gap turns bright, or a tenth character appears. Each sample is compared against a model of the expected picture, so one bad clock at the output is reported at that line and offset.

// File: rtl/osd_pkg.sv
package osd_pkg;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_WAIT = 2'd1,
        SER_DRAW = 2'd2
    } ser_state_e;

endpackage

// File: rtl/osd_line_tracker.sv
module osd_line_tracker #(
    parameter int LINE_W     = 10,
    parameter int DRAW_LINES = 16,
    parameter int REPEAT     = 2,
    parameter int CELL_ROWS  = 7,
    parameter int ROW_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic [LINE_W-1:0] start_line_i,
    output logic              hs_edge_o,
    output logic              vis_o,
    output logic [ROW_W-1:0]  row_o
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [LINE_W-1:0] SPAN     = LINE_W'(DRAW_LINES);
    localparam logic [LINE_W-1:0] REP      = LINE_W'(REPEAT);
    localparam logic [LINE_W-1:0] ROWS     = LINE_W'(CELL_ROWS);

    typedef struct packed {
        logic              hs_prev;
        logic              vs_prev;
        logic [LINE_W-1:0] line;
        logic              vis;
        logic [ROW_W-1:0]  row;
    } trk_t;

    trk_t q, d;
    logic              hs_edge, vs_edge;
    logic [LINE_W-1:0] next_line, rel, row_full;

    always_comb begin
        hs_edge   = hsync_i & ~q.hs_prev;
        vs_edge   = vsync_i & ~q.vs_prev;
        next_line = (q.line == LINE_MAX) ? q.line : q.line + 1'b1;
        rel       = next_line - start_line_i;
        row_full  = rel / REP;

        d         = q;
        d.hs_prev = hsync_i;
        d.vs_prev = vsync_i;
        if (vs_edge) begin
            d.line = '0;
            d.vis  = 1'b0;
            d.row  = '0;
        end else if (hs_edge) begin
            d.line = next_line;
            if ((next_line >= start_line_i) && (rel < SPAN) && (row_full < ROWS)) begin
                d.vis = 1'b1;
                d.row = row_full[ROW_W-1:0];
            end else begin
                d.vis = 1'b0;
                d.row = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hs_edge_o = hs_edge;
    assign vis_o     = q.vis;
    assign row_o     = q.row;

    // R2: a vertical sync edge empties the line count and the band
    assert_vsync_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vs_edge |=> (q.line == '0 && !q.vis));

    // R9: without a fresh edge, a held sync level leaves the count alone
    assert_held_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_edge && !vs_edge) |=> ($stable(q.line) && $stable(q.vis)));

endmodule

// File: rtl/osd_char_buffer.sv
module osd_char_buffer #(
    parameter int NUM_CHARS = 9,
    parameter int CELL_ROWS = 7,
    parameter int CELL_DOTS = 8,
    parameter int ADDR_W    = 6,
    parameter int ROW_W     = 4,
    parameter int CHAR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [CELL_DOTS-1:0] wr_data_i,
    input  logic [ROW_W-1:0]     rd_row_i,
    input  logic [CHAR_W-1:0]    rd_char_i,
    output logic [CELL_DOTS-1:0] font_o
);

    localparam int DEPTH = NUM_CHARS * CELL_ROWS;
    localparam int RA_W  = ADDR_W + 1;
    localparam logic [RA_W-1:0]   RA_DEPTH = RA_W'(DEPTH);
    localparam logic [RA_W-1:0]   RA_NCH   = RA_W'(NUM_CHARS);
    localparam logic [ADDR_W-1:0] WA_DEPTH = ADDR_W'(DEPTH);

    logic [CELL_DOTS-1:0] mem_q [DEPTH];
    logic [CELL_DOTS-1:0] mem_d [DEPTH];
    logic [RA_W-1:0]      rd_addr;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && (wr_addr_i < WA_DEPTH)) begin
            mem_d[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_addr = RA_W'(rd_row_i) * RA_NCH + RA_W'(rd_char_i);
        if (rd_addr < RA_DEPTH) font_o = mem_q[rd_addr[ADDR_W-1:0]];
        else                    font_o = '0;
    end

endmodule

// File: rtl/osd_dot_serializer.sv
module osd_dot_serializer
    import osd_pkg::*;
#(
    parameter int NUM_CHARS = 9,
    parameter int CELL_DOTS = 8,
    parameter int DOT_CLKS  = 2,
    parameter int GAP_CLKS  = 6,
    parameter int DELAY_W   = 8,
    parameter int CHAR_W    = 4,
    parameter int PH_W      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hs_edge_i,
    input  logic                 vis_i,
    input  logic [DELAY_W-1:0]   h_delay_i,
    input  logic [CELL_DOTS-1:0] font_i,
    output logic [CHAR_W-1:0]    char_o,
    output logic                 ovl_o
);

    localparam int CHAR_CLKS = CELL_DOTS * DOT_CLKS + GAP_CLKS;
    localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(CHAR_CLKS - 1);
    localparam logic [PH_W-1:0]   DOT_SPAN = PH_W'(CELL_DOTS * DOT_CLKS);
    localparam logic [PH_W-1:0]   DCLK     = PH_W'(DOT_CLKS);
    localparam logic [CHAR_W-1:0] CH_LAST  = CHAR_W'(NUM_CHARS - 1);

    typedef struct packed {
        ser_state_e         state;
        logic [DELAY_W-1:0] dly;
        logic [PH_W-1:0]    ph;
        logic [CHAR_W-1:0]  chr;
        logic               ovl;
    } ser_t;

    ser_t q, d;
    logic [PH_W-1:0]      dot_idx;
    logic [CELL_DOTS-1:0] shifted;

    always_comb begin
        dot_idx = q.ph / DCLK;
        shifted = font_i << dot_idx;

        d     = q;
        d.ovl = 1'b0;
        unique case (q.state)
            SER_WAIT: begin
                if (q.dly == '0) begin
                    d.state = SER_DRAW;
                    d.ph    = '0;
                    d.chr   = '0;
                end else begin
                    d.dly = q.dly - 1'b1;
                end
            end
            SER_DRAW: begin
                if (q.ph < DOT_SPAN) d.ovl = vis_i & shifted[CELL_DOTS-1];
                if (q.ph == PH_LAST) begin
                    d.ph = '0;
                    if (q.chr == CH_LAST) d.state = SER_IDLE;
                    else                  d.chr   = q.chr + 1'b1;
                end else begin
                    d.ph = q.ph + 1'b1;
                end
            end
            default: ;
        endcase

        if (hs_edge_i) begin
            d.state = SER_WAIT;
            d.dly   = h_delay_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign char_o = q.chr;
    assign ovl_o  = q.ovl;

    // R5: while drawing, character index and phase stay inside the row
    assert_char_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SER_DRAW) |-> (q.chr <= CH_LAST && q.ph <= PH_LAST));

    // R6: every sync edge restarts the horizontal delay from the setting
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_edge_i |=> (q.state == SER_WAIT && q.dly == $past(h_delay_i)));

    // R7: gap slots of a character never light the output
    assert_gap_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SER_DRAW && q.ph >= DOT_SPAN) |=> !q.ovl);

endmodule

// File: rtl/osd_overlay_gen.sv
module osd_overlay_gen #(
    parameter int NUM_CHARS  = 9,
    parameter int CELL_ROWS  = 7,
    parameter int CELL_DOTS  = 8,
    parameter int DRAW_LINES = 16,
    parameter int REPEAT     = 2,
    parameter int DOT_CLKS   = 2,
    parameter int GAP_CLKS   = 6,
    parameter int LINE_W     = 10,
    parameter int DELAY_W    = 8,
    parameter int ADDR_W     = $clog2(NUM_CHARS * CELL_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hsync_i,
    input  logic                 vsync_i,
    input  logic [LINE_W-1:0]    start_line_i,
    input  logic [DELAY_W-1:0]   h_delay_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [CELL_DOTS-1:0] wr_data_i,
    output logic                 ovl_o
);

    localparam int CHAR_CLKS = CELL_DOTS * DOT_CLKS + GAP_CLKS;
    localparam int ROW_W     = $clog2(DRAW_LINES);
    localparam int CHAR_W    = $clog2(NUM_CHARS);
    localparam int PH_W      = $clog2(CHAR_CLKS);

    logic                 hs_edge, vis;
    logic [ROW_W-1:0]     row;
    logic [CHAR_W-1:0]    chr;
    logic [CELL_DOTS-1:0] font;

    osd_line_tracker #(
        .LINE_W(LINE_W), .DRAW_LINES(DRAW_LINES), .REPEAT(REPEAT),
        .CELL_ROWS(CELL_ROWS), .ROW_W(ROW_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .start_line_i(start_line_i), .hs_edge_o(hs_edge), .vis_o(vis), .row_o(row)
    );

    osd_char_buffer #(
        .NUM_CHARS(NUM_CHARS), .CELL_ROWS(CELL_ROWS), .CELL_DOTS(CELL_DOTS),
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .CHAR_W(CHAR_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_row_i(row), .rd_char_i(chr), .font_o(font)
    );

    osd_dot_serializer #(
        .NUM_CHARS(NUM_CHARS), .CELL_DOTS(CELL_DOTS), .DOT_CLKS(DOT_CLKS),
        .GAP_CLKS(GAP_CLKS), .DELAY_W(DELAY_W), .CHAR_W(CHAR_W), .PH_W(PH_W)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .hs_edge_i(hs_edge), .vis_i(vis),
        .h_delay_i(h_delay_i), .font_i(font), .char_o(chr), .ovl_o(ovl_o)
    );

    // R3: a lit dot always follows a cycle in which the line was in the band
    assert_dark_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_o |-> $past(vis));

endmodule

// File: tb/osd_overlay_gen_test.sv
module osd_overlay_gen_test;

    localparam int NCH       = 9;
    localparam int NROW      = 7;
    localparam int DEPTH     = NCH * NROW;
    localparam int CHAR_CLKS = 22;
    localparam int LINE_CLKS = 260;
    localparam int NCFG      = 4;
    // start line, delay, hsync width
    localparam int CFG [NCFG][3] = '{'{3, 5, 3}, '{10, 0, 1}, '{1, 40, 7}, '{0, 12, 2}};

    logic       clk = 1'b0;
    logic       rst_n, hsync_i, vsync_i, wr_en_i;
    logic [9:0] start_line_i;
    logic [7:0] h_delay_i, wr_data_i;
    logic [5:0] wr_addr_i;
    logic       ovl_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    osd_overlay_gen uut (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .start_line_i(start_line_i), .h_delay_i(h_delay_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .ovl_o(ovl_o)
    );

    task automatic check(input logic got, input logic exp, input string req,
                         input int k, input int n);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s line %0d clk %0d: got %0b expected %0b", req, k, n, got, exp);
        end
    endtask

    task automatic write_byte(input int a, input logic [7:0] v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (a < DEPTH) model[a] = v;
    endtask

    task automatic load_pattern(input int s);
        for (int a = 0; a < DEPTH; a++)
            write_byte(a, 8'((a * 29 + s * 71 + 90) ^ (a << 3)));
        write_byte(5, 8'hFF);
        write_byte(13, 8'h00);
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync_i = 1'b1;
        repeat (3) @(negedge clk);
        vsync_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic expect_dot(input int k, input int n, input int st,
                                        input int dl, output string req);
        int rel, row, x, c, p;
        rel = k - st;
        if (k < st || rel >= 16) begin req = "R3"; return 1'b0; end
        row = rel / 2;
        if (row >= NROW) begin req = "R4"; return 1'b0; end
        x = n - dl - 2;
        if (x < 0 || x >= NCH * CHAR_CLKS) begin req = "R6"; return 1'b0; end
        c = x / CHAR_CLKS;
        p = x % CHAR_CLKS;
        if (p >= 16) begin req = "R7"; return 1'b0; end
        req = "R5";
        return model[row * NCH + c][7 - p / 2];
    endfunction

    task automatic run_line(input int k, input int st, input int dl,
                            input int hw, input string extra);
        string req;
        logic  exp;
        @(negedge clk); hsync_i = 1'b1;
        for (int n = 0; n < LINE_CLKS; n++) begin
            @(negedge clk);
            exp = expect_dot(k, n, st, dl, req);
            check(ovl_o, exp, {req, extra}, k, n);
            if (n == hw - 1) hsync_i = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0; wr_en_i = 1'b0;
        wr_addr_i = '0; wr_data_i = '0; start_line_i = '0; h_delay_i = '0;
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        check(ovl_o, 1'b0, "R1 reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ovl_o, 1'b0, "R1 after reset", 0, 0);

        load_pattern(0);

        // Table walk: each configuration is drawn as a full frame
        for (int f = 0; f < NCFG; f++) begin
            string extra;
            start_line_i = 10'(CFG[f][0]);
            h_delay_i    = 8'(CFG[f][1]);
            if (f > 0) begin
                load_pattern(f);
                write_byte(63, 8'hFF);   // R8: out-of-range write ignored
                pulse_vsync();
                extra = " R2 R8";
            end else begin
                extra = " R1";
            end
            if (CFG[f][2] > 1) extra = {extra, " R9"};
            for (int k = 1; k <= CFG[f][0] + 18; k++)
                run_line(k, CFG[f][0], CFG[f][1], CFG[f][2], extra);
        end

        // Directed: vertical sync in the middle of the band restarts the count
        start_line_i = 10'd2;
        h_delay_i    = 8'd3;
        pulse_vsync();
        for (int k = 1; k <= 4; k++) run_line(k, 2, 3, 1, " R2 mid");
        pulse_vsync();
        for (int k = 1; k <= 6; k++) run_line(k, 2, 3, 1, " R2 restart");

        // Directed: a write between lines shows on the next line of that row
        write_byte(0, 8'hA5);
        write_byte(8, 8'h81);
        pulse_vsync();
        for (int k = 1; k <= 4; k++) run_line(k, 2, 3, 2, " R8 rewrite");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule